// File: doc/BRIEF.md
# Serial Command Frame Transmitter for a Dual-Channel DAC

This block sits on the host side of a three-wire serial link to a dual-channel digital-to-analog converter. It takes one request at a time over a valid/ready handshake. A request holds a 4-bit command, a 4-bit channel address and a 12-bit code. The block serialises the request into a frame on an active-low select/load line, a serial clock and a serial data line. The converter acts on the frame when select/load returns high. At that moment the block raises a single-cycle completion pulse.

A frame is normally 24 bits long. When the request's long-frame flag is set, eight zero pad bits go ahead of the 24-bit word, which gives a 32-bit frame for hosts that work in whole bytes. Every timing interval on the link is a count of system-clock cycles set by a parameter: the half-period of the serial clock, the delay from select to the first clock, the hold after the last bit, and the gap between frames. One build therefore meets the converter's timing at any system clock rate, provided the parameters are chosen for that rate.

Top module: `dac_frame_tx`

## Requirements
- R1: Synchronous reset drives the link idle: `ser_sel_n` is 1, `ser_clk` is 0 and `ser_dat` is 0. `frame_done` is 0 and `req_ready` is 1.
- R2: In a short frame (`req_long`=0), 24 bits are sent, one per rising `ser_clk` edge. The order is `req_cmd` bit 3 down to bit 0, then `req_addr` bit 3 down to bit 0, then `req_code` bit 11 down to bit 0, then four zero bits.
- R3: In a long frame (`req_long`=1), eight zero bits are sent first, followed by the same 24 bits in the same order as R2.
- R4: `ser_dat` changes only while `ser_clk` is low, on the falling edge, and never in the cycle where `ser_clk` rises.
- R5: Each high phase and each low phase of `ser_clk` inside a frame lasts exactly SCLK_HALF system cycles.
- R6: The first rising `ser_clk` edge comes exactly SETUP_CYC cycles after `ser_sel_n` falls. `ser_sel_n` rises exactly 2*SCLK_HALF+HOLD_CYC cycles after the last rising `ser_clk` edge.
- R7: `ser_clk` is low in every cycle in which `ser_sel_n` is high.
- R8: `frame_done` is high for exactly one cycle, and that cycle is the first one in which `ser_sel_n` is high again after a frame.
- R9: `req_ready` is low from the cycle after a request is accepted until GAP_CYC cycles after `ser_sel_n` rises. A request held valid is therefore started with `ser_sel_n` high for exactly GAP_CYC+1 cycles between frames.
- R10: Request inputs presented while `req_ready` is low have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 4 | Channel address nibble |
| req_code | input | CODE_W | Converter code, placed at the top of the 16-bit data field |
| req_long | input | 1 | 1 selects the 32-bit frame with eight leading pad bits |
| ser_sel_n | output | 1 | Active-low select/load to the converter |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dat | output | 1 | Serial data, updated on falling clock edges |
| frame_done | output | 1 | One-cycle pulse when select/load returns high |

## Verification
The hardest case to reach is a request that arrives while a frame is still in progress. It shows both the inter-frame gap (R9) and the rule that the inputs are ignored while the block is busy (R10). The stimulus keeps `req_valid` high with a different request right after the first one is accepted. It then checks two things: the first frame still carries the original fields, and the second frame starts only after exactly GAP_CYC+1 cycles with select high. Long and short frames with all-ones and all-zeros fields are also sent, so that pad bits and field boundaries cannot be confused.

// File: rtl/dac_tx_pkg.sv
// Shared constants and types for the serial DAC frame transmitter.
// Assumes the fixed frame layout: 4-bit command, 4-bit address,
// 16-bit data field, optional 8-bit leading pad.
package dac_tx_pkg;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int FIELD_W = 16;
    localparam int LEAD_W  = 8;
    localparam int WORD_W  = CMD_W + ADDR_W + FIELD_W;
    localparam int LONG_W  = LEAD_W + WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_HOLD,
        ST_GAP
    } tx_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/dac_frame_pack.sv
// Combinational frame builder: packs command, address and a left-justified
// code into a frame aligned to the MSB, and reports its bit count.
// Assumes CODE_W <= FIELD_W; unused low bits of the field are zero.
module dac_frame_pack
    import dac_tx_pkg::*;
#(
    parameter int CODE_W = 12,
    localparam int BITS_W = $clog2(LONG_W + 1)
) (
    input  logic [CMD_W-1:0]  cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] code,
    input  logic              long_mode,
    output logic [LONG_W-1:0] frame,
    output logic [BITS_W-1:0] nbits
);
    logic [FIELD_W-1:0] field;
    logic [WORD_W-1:0]  word;

    // Left-justify the code inside the data field.
    generate
        if (CODE_W < FIELD_W) begin : g_pad
            assign field = {code, {(FIELD_W - CODE_W){1'b0}}};
        end else begin : g_full
            assign field = code;
        end
    endgenerate

    // Assemble the word and place it according to the frame length.
    always_comb begin
        word  = {cmd, addr, field};
        frame = long_mode ? {{LEAD_W{1'b0}}, word} : {word, {LEAD_W{1'b0}}};
        nbits = long_mode ? BITS_W'(LONG_W) : BITS_W'(WORD_W);
    end
endmodule

// File: rtl/dac_phase_timer.sv
// Down counter that measures one link phase in system-clock cycles.
// A phase loaded with value v lasts v+1 cycles; expired is high in its last cycle.
module dac_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dac_bit_shifter.sv
// MSB-first output shift register with a count of bits still to be sent.
// Zeros are shifted in, so the output rests at 0 once the frame is out.
module dac_bit_shifter #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  load_word,
    input  logic [CW-1:0] load_count,
    input  logic          shift,
    output logic          bit_out,
    output logic          empty
);
    logic [W-1:0]  sr_q;
    logic [CW-1:0] left_q;

    // Capture a frame, or advance by one bit on each shift request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sr_q   <= load_word;
            left_q <= load_count;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
            if (left_q != '0) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign bit_out = sr_q[W-1];
    assign empty   = (left_q == '0);
endmodule

// File: rtl/dac_frame_tx.sv
// Serial command frame transmitter for a dual-channel DAC.
// Accepts one request per frame over valid/ready and drives select/load,
// serial clock and data. All link intervals are parameters counted in
// system-clock cycles. Assumes SCLK_HALF, SETUP_CYC, HOLD_CYC and GAP_CYC
// are all at least 1.
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter int SCLK_HALF = 2,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [3:0]        req_addr,
    input  logic [CODE_W-1:0] req_code,
    input  logic              req_long,
    output logic              ser_sel_n,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              frame_done
);
    localparam int TMR_MAX = max2(max2(SCLK_HALF, SETUP_CYC), max2(HOLD_CYC, GAP_CYC));
    localparam int TMR_W   = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);
    localparam int BITS_W  = $clog2(LONG_W + 1);

    localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] T_HALF  = TMR_W'(SCLK_HALF - 1);
    localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] T_GAP   = TMR_W'(GAP_CYC - 1);

    tx_state_e         st_q, st_d;
    logic              sel_q, sel_d;
    logic              sck_q, sck_d;
    logic              done_q, done_d;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              sh_load, sh_shift, sh_empty;
    logic [LONG_W-1:0] frame_w;
    logic [BITS_W-1:0] nbits_w;

    dac_frame_pack #(.CODE_W(CODE_W)) u_pack (
        .cmd       (req_cmd),
        .addr      (req_addr),
        .code      (req_code),
        .long_mode (req_long),
        .frame     (frame_w),
        .nbits     (nbits_w)
    );

    dac_phase_timer #(.CW(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dac_bit_shifter #(.W(LONG_W), .CW(BITS_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_word  (frame_w),
        .load_count (nbits_w),
        .shift      (sh_shift),
        .bit_out    (ser_dat),
        .empty      (sh_empty)
    );

    // Sequence the phases of a frame and decide the next link levels.
    always_comb begin
        st_d     = st_q;
        sel_d    = sel_q;
        sck_d    = sck_q;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d     = ST_SETUP;
                    sel_d    = 1'b0;
                    sh_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    st_d     = ST_HIGH;
                    sck_d    = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    st_d     = ST_LOW;
                    sck_d    = 1'b0;
                    sh_shift = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (sh_empty) begin
                        st_d    = ST_HOLD;
                        tmr_val = T_HOLD;
                    end else begin
                        st_d    = ST_HIGH;
                        sck_d   = 1'b1;
                        tmr_val = T_HALF;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    st_d     = ST_GAP;
                    sel_d    = 1'b1;
                    done_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Register the state and the link outputs so they leave glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sel_q  <= 1'b1;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            sel_q  <= sel_d;
            sck_q  <= sck_d;
            done_q <= done_d;
        end
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign ser_sel_n  = sel_q;
    assign ser_clk    = sck_q;
    assign frame_done = done_q;
endmodule

// File: rtl/dac_frame_tx_chk.sv
// Protocol checker for dac_frame_tx, attached by bind. It observes ports
// only and uses its own run-length counters for the timing windows.
module dac_frame_tx_chk #(
    parameter int SCLK_HALF = 2,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic ser_sel_n,
    input logic ser_clk,
    input logic ser_dat,
    input logic frame_done
);
    logic [15:0] hi_run, sel_low_run, since_rise;

    // Count consecutive clock-high samples, samples since select fell,
    // and samples since the last clock rise (all saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run      <= '0;
            sel_low_run <= '0;
            since_rise  <= '0;
        end else begin
            hi_run      <= ser_clk ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
            sel_low_run <= ser_sel_n ? '0 : ((sel_low_run == 16'hFFFF) ? sel_low_run : sel_low_run + 1'b1);
            since_rise  <= (ser_clk && !$past(ser_clk)) ? 16'd1
                         : ((since_rise == 16'hFFFF) ? since_rise : since_rise + 1'b1);
        end
    end

    assert_clk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel_n |-> !ser_clk);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    assert_done_at_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_sel_n) |-> frame_done);
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_sel_n |-> !req_ready);
    assert_dat_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));
    assert_dat_stable_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dat));
    assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_clk) |-> (hi_run == 16'(SCLK_HALF)));
    assert_sel_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> (sel_low_run >= 16'(SETUP_CYC)));
    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_sel_n) |-> (since_rise == 16'(2 * SCLK_HALF + HOLD_CYC)));
endmodule

bind dac_frame_tx dac_frame_tx_chk #(
    .SCLK_HALF (SCLK_HALF),
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .GAP_CYC   (GAP_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .ser_sel_n  (ser_sel_n),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .frame_done (frame_done)
);

// File: tb/dac_frame_tx_tb_top.sv
// Bench: a behavioural per-cycle expectation queue, compared on every clock,
// plus frame capture and timing monitors working only from the ports.
module dac_frame_tx_tb_top;
    localparam int CODE_W = 12;
    localparam int HALF   = 2;
    localparam int SETUP  = 2;
    localparam int HOLD   = 1;
    localparam int GAP    = 1;

    typedef struct packed {
        logic sel_n;
        logic sck;
        logic sd;
        logic done;
        logic rdy;
    } exp_t;

    localparam exp_t IDLE_EXP = '{sel_n: 1'b1, sck: 1'b0, sd: 1'b0, done: 1'b0, rdy: 1'b1};

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready, req_long;
    logic [3:0] req_cmd, req_addr;
    logic [CODE_W-1:0] req_code;
    logic ser_sel_n, ser_clk, ser_dat, frame_done;

    int n_chk = 0;
    int n_err = 0;
    exp_t q[$];
    logic exp_bits[$][$];
    string frame_tags[$];
    logic cap[$];
    string next_tag = "R2";
    string sd_tag = "R2";
    logic acc;
    logic prev_sel = 1'b1, prev_sck = 1'b0, prev_dat = 1'b0;
    int since_fall = 0, since_rise = 0, hi_run = 0;
    logic first_pending = 1'b0;
    logic expect_b2b = 1'b0;

    always #10 clk = ~clk;

    dac_frame_tx #(
        .CODE_W(CODE_W), .SCLK_HALF(HALF), .SETUP_CYC(SETUP),
        .HOLD_CYC(HOLD), .GAP_CYC(GAP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_code(req_code),
        .req_long(req_long), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .frame_done(frame_done)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Expected frame bits and the per-cycle waveform of one frame.
    task automatic push_frame(input logic [3:0] c, input logic [3:0] a,
                              input logic [CODE_W-1:0] code, input logic lng);
        logic bits[$];
        int n;
        if (lng) for (int i = 0; i < 8; i++) bits.push_back(1'b0);
        for (int i = 3; i >= 0; i--) bits.push_back(c[i]);
        for (int i = 3; i >= 0; i--) bits.push_back(a[i]);
        for (int i = CODE_W - 1; i >= 0; i--) bits.push_back(code[i]);
        for (int i = 0; i < 16 - CODE_W; i++) bits.push_back(1'b0);
        n = bits.size();
        for (int k = 0; k < SETUP; k++) q.push_back('{1'b0, 1'b0, bits[0], 1'b0, 1'b0});
        for (int j = 0; j < n; j++) begin
            for (int k = 0; k < HALF; k++) q.push_back('{1'b0, 1'b1, bits[j], 1'b0, 1'b0});
            for (int k = 0; k < HALF; k++)
                q.push_back('{1'b0, 1'b0, (j + 1 < n) ? bits[j + 1] : 1'b0, 1'b0, 1'b0});
        end
        for (int k = 0; k < HOLD; k++) q.push_back('{1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
        q.push_back('{1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
        for (int k = 1; k < GAP; k++) q.push_back('{1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
        exp_bits.push_back(bits);
        frame_tags.push_back(next_tag);
    endtask

    // Port monitors: frame capture and timing measurements (R2-R9).
    task automatic monitor();
        if (!ser_sel_n && prev_sel) begin
            since_fall = 0;
            first_pending = 1'b1;
            if (expect_b2b) begin
                check("R9", "select-high cycles between frames", 32'(hi_run), 32'(GAP + 1));
                expect_b2b = 1'b0;
            end
        end else begin
            since_fall++;
        end
        hi_run = ser_sel_n ? hi_run + 1 : 0;
        if (ser_sel_n) check("R7", "clock low while deselected", 32'(ser_clk), 32'd0);
        if (ser_clk && prev_sck) check("R4", "data stable while clock high", 32'(ser_dat), 32'(prev_dat));
        if (ser_clk && !prev_sck) begin
            cap.push_back(ser_dat);
            if (first_pending) begin
                check("R6", "select fall to first clock rise", 32'(since_fall), 32'(SETUP));
                first_pending = 1'b0;
            end
            since_rise = 0;
        end else begin
            since_rise++;
        end
        if (ser_sel_n && !prev_sel) begin
            check("R6", "last clock rise to select rise", 32'(since_rise), 32'(2 * HALF + HOLD));
            if (exp_bits.size() > 0) begin
                logic eb[$];
                string tg;
                eb = exp_bits.pop_front();
                tg = frame_tags.pop_front();
                check(tg, "frame length", 32'(cap.size()), 32'(eb.size()));
                for (int i = 0; i < eb.size() && i < cap.size(); i++)
                    check(tg, $sformatf("frame bit %0d", i), 32'(cap[i]), 32'(eb[i]));
            end
            cap.delete();
        end
        prev_sel = ser_sel_n;
        prev_sck = ser_clk;
        prev_dat = ser_dat;
    endtask

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic step();
        exp_t cur, nxt;
        @(posedge clk);
        cur = (q.size() > 0) ? q[0] : IDLE_EXP;
        acc = req_valid && cur.rdy;
        if (q.size() > 0) void'(q.pop_front());
        if (acc) begin
            sd_tag = req_long ? "R3" : "R2";
            push_frame(req_cmd, req_addr, req_code, req_long);
        end
        @(negedge clk);
        nxt = (q.size() > 0) ? q[0] : IDLE_EXP;
        check("R6", "select level", 32'(ser_sel_n), 32'(nxt.sel_n));
        check("R5", "serial clock level", 32'(ser_clk), 32'(nxt.sck));
        check(sd_tag, "serial data level", 32'(ser_dat), 32'(nxt.sd));
        check("R8", "done pulse", 32'(frame_done), 32'(nxt.done));
        check("R9", "ready level", 32'(req_ready), 32'(nxt.rdy));
        monitor();
    endtask

    task automatic present(input logic [3:0] c, input logic [3:0] a,
                           input logic [CODE_W-1:0] code, input logic lng, input string tag);
        req_valid = 1'b1;
        req_cmd   = c;
        req_addr  = a;
        req_code  = code;
        req_long  = lng;
        next_tag  = tag;
    endtask

    task automatic send(input logic [3:0] c, input logic [3:0] a,
                        input logic [CODE_W-1:0] code, input logic lng, input string tag);
        present(c, a, code, lng, tag);
        do step(); while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) step();
        step();
        step();
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_cmd = '0;
        req_addr = '0;
        req_code = '0;
        req_long = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", "reset select", 32'(ser_sel_n), 32'd1);
        check("R1", "reset clock", 32'(ser_clk), 32'd0);
        check("R1", "reset data", 32'(ser_dat), 32'd0);
        check("R1", "reset done", 32'(frame_done), 32'd0);
        check("R1", "reset ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        step();

        // R2: short frame with a mixed pattern
        send(4'h3, 4'h0, 12'hA5C, 1'b0, "R2");
        wait_idle();
        // R3: long frame, all-ones fields behind the zero pad
        send(4'h0, 4'hF, 12'hFFF, 1'b1, "R3");
        wait_idle();
        // R2: all-zero code with non-zero command and address
        send(4'hF, 4'h1, 12'h000, 1'b0, "R2");
        wait_idle();

        // R10 and R9: a second request waits while the first is in flight
        send(4'h2, 4'h1, 12'h5A3, 1'b0, "R10");
        present(4'hC, 4'hE, 12'h0F0, 1'b1, "R9");
        expect_b2b = 1'b1;
        do step(); while (!acc);
        req_valid = 1'b0;
        wait_idle();
        check("R9", "back-to-back gap was measured", 32'(expect_b2b), 32'd0);

        // R3: long frame with only the code MSB set
        send(4'h1, 4'h0, 12'h800, 1'b1, "R3");
        wait_idle();

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule